// File: doc/BRIEF.md
# UART Register Window with Receive Queue and Interrupt Status

This block is the register-facing half of a serial port. A host reads and writes 32-bit words through a simple select/write strobe bus, and a separate deserializer hands received bytes in over a valid/ready pair. Incoming bytes land in a receive queue. Bit 4 of the line-control register sets the queue's capacity: sixteen entries, or a single holding slot. Reading the data word pops the oldest byte. Writing the data word sends a byte out on a one-cycle strobe to the transmit side.

Two interrupt sources are kept, receive and transmit. Each has a raw status bit, a mask bit and a write-one-to-clear path, and one interrupt output is driven from the masked sources. A flag word reports whether the queue is empty or full. The block also stores the divisor, line-control, control, FIFO-level and DMA-control words for the bit engine that sits around it, and the top eight words of the window return a fixed identification byte sequence.

Top module: `uart_regs_top`

## Requirements
- R1: After reset the flag word (word 6) reads 0x90, the FIFO-level word (13) reads 0x12, the control word (12) reads 0x300, raw status (15) reads 0, `irq` is 0 and `rx_ready` is 1.
- R2: When line-control bit 4 is 0 the queue holds one byte, so `rx_ready` is high only while it is empty. A byte offered while `rx_ready` is low is not taken and the held byte is kept.
- R3: When line-control bit 4 is 1 the queue holds 16 bytes. `rx_ready` drops at 16 entries and the bytes are read back from word 0 (bits 7:0) in arrival order.
- R4: Flag bit 4 (receive empty) is cleared by an accepted byte and set by a data read that leaves the queue empty. Flag bit 6 (receive full) is set by an accepted byte that brings the count to 16 or that arrives while control bit 4 is 1, and is cleared by any data read. Bit 7 reads 1 and bit 5 reads 0.
- R5: The receive raw bit (bit 4) is set when an accepted byte brings the count to 1. It is cleared when a data read leaves the count at 0.
- R6: A write to word 0 drives `tx_strobe` high for exactly the next cycle, with `tx_data` equal to the written bits 7:0, and sets the transmit raw bit (bit 5).
- R7: Word 14 is the mask. Word 15 returns raw status and word 16 returns raw AND mask, both in bits 5:4. A write to word 17 clears the raw bits where the value has ones. `irq` is high when any raw bit is set together with its mask bit. A new event in the same cycle as a clear wins.
- R8: Words 9, 10, 11, 12, 13 and 18 store the low 16 bits of the written value and read them back zero-extended.
- R9: The last eight words of the window (1016 to 1023 with the default address width) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order.
- R10: Words with no assigned register read 0, and writes to them change no stored register.
- R11: A data read and an accepted byte in the same cycle pop the head and append the new byte, and the flag and raw updates of the byte take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Queue can take a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle pulse per transmit byte |
| irq | output | 1 | Masked interrupt output |

## Verification
Read data and `rx_ready` are combinational from registered state, so the bench checks them within the access cycle, shortly after driving the inputs. Pops, pushes, flag and raw-status updates, `irq` and `tx_strobe` change at the next rising edge, so the bench updates its queue model at that edge and compares these outputs at the following falling edge. A read that follows a write always lands one cycle later and sees the updated state. The model keeps no registers of its own beyond a byte queue and a handful of integers.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
    localparam int CFG_W  = 16;
    localparam int BYTE_W = 8;

    localparam int WORD_DATA  = 0;
    localparam int WORD_FLAGS = 6;
    localparam int WORD_IDIV  = 9;
    localparam int WORD_FDIV  = 10;
    localparam int WORD_LINE  = 11;
    localparam int WORD_CTRL  = 12;
    localparam int WORD_LEVEL = 13;
    localparam int WORD_MASK  = 14;
    localparam int WORD_RAW   = 15;
    localparam int WORD_MSTAT = 16;
    localparam int WORD_ICLR  = 17;
    localparam int WORD_DMA   = 18;

    localparam int LINE_QUEUE_BIT = 4;
    localparam int CTRL_FULL_BIT  = 4;

    typedef struct packed {
        logic tx;
        logic rx;
    } int_bits_t;

    typedef struct packed {
        logic [CFG_W-1:0]  idiv;
        logic [CFG_W-1:0]  fdiv;
        logic [CFG_W-1:0]  line;
        logic [CFG_W-1:0]  ctrl;
        logic [CFG_W-1:0]  level;
        logic [CFG_W-1:0]  dma;
        logic [CFG_W-1:0]  mask;
        logic              rx_full;
        logic              rx_empty;
        logic              tx_stb;
        logic [BYTE_W-1:0] tx_byte;
    } regs_t;
endpackage

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              ready,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cnt_after_pop,
    output logic [CNT_W-1:0]  cnt_next
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [CNT_W-1:0] count;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cap;
    logic              pop_eff;
    logic [CNT_W:0]    tail_sum;
    logic [IDX_W-1:0]  tail;
    logic [CNT_W:0]    head_inc;

    always_comb begin
        cap       = single_mode ? CNT_W'(1) : CNT_W'(DEPTH);
        ready     = st_q.count < cap;
        pop_eff   = pop && (st_q.count != '0);
        cnt_after_pop = st_q.count - CNT_W'(pop_eff);
        cnt_next  = cnt_after_pop + CNT_W'(push);
        tail_sum  = (CNT_W+1)'(st_q.head) + (CNT_W+1)'(st_q.count);
        if (tail_sum >= (CNT_W+1)'(DEPTH)) tail_sum = tail_sum - (CNT_W+1)'(DEPTH);
        tail      = IDX_W'(tail_sum);
        head_inc  = (CNT_W+1)'(st_q.head) + (CNT_W+1)'(1);
        if (head_inc >= (CNT_W+1)'(DEPTH)) head_inc = '0;

        st_d = st_q;
        if (pop_eff) st_d.head = IDX_W'(head_inc);
        st_d.count = cnt_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail] <= push_data;
    end

    assign head_data = mem[st_q.head];
    assign count     = st_q.count;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_eff) |=> (st_q.count == $past(st_q.count) + CNT_W'(1)));
endmodule

// File: rtl/uart_int_status.sv
`timescale 1ns/1ps
module uart_int_status
    import uart_regs_pkg::*;
#(
    parameter int TRIGGER = 1,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  int_bits_t        clr_bits,
    input  logic             pop,
    input  logic             push,
    input  logic [CNT_W-1:0] cnt_after_pop,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             tx_set,
    input  int_bits_t        mask,
    output int_bits_t        raw,
    output logic             irq
);
    int_bits_t raw_d, raw_q;

    always_comb begin
        raw_d = raw_q;
        if (clr_en) raw_d = raw_d & ~clr_bits;
        if (pop && cnt_after_pop == CNT_W'(TRIGGER - 1)) raw_d.rx = 1'b0;
        if (push && cnt_next == CNT_W'(TRIGGER)) raw_d.rx = 1'b1;
        if (tx_set) raw_d.tx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw = raw_q;
    assign irq = |(raw_q & mask);

    assert_rx_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q.rx) |-> $past(push));

    assert_tx_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q.tx) |-> $past(tx_set));
endmodule

// File: rtl/uart_ident_rom.sv
`timescale 1ns/1ps
module uart_ident_rom (
    input  logic [2:0] sel,
    output logic [7:0] value
);
    always_comb begin
        case (sel)
            3'd0:    value = 8'h11;
            3'd1:    value = 8'h10;
            3'd2:    value = 8'h14;
            3'd3:    value = 8'h00;
            3'd4:    value = 8'h0D;
            3'd5:    value = 8'hF0;
            3'd6:    value = 8'h05;
            default: value = 8'hB1;
        endcase
    end
endmodule

// File: rtl/uart_regs_top.sv
`timescale 1ns/1ps
module uart_regs_top
    import uart_regs_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 10,
    parameter int RX_TRIGGER = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_strobe,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(WORD_DATA);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(WORD_FLAGS);
    localparam logic [ADDR_W-1:0] A_IDIV  = ADDR_W'(WORD_IDIV);
    localparam logic [ADDR_W-1:0] A_FDIV  = ADDR_W'(WORD_FDIV);
    localparam logic [ADDR_W-1:0] A_LINE  = ADDR_W'(WORD_LINE);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(WORD_CTRL);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(WORD_LEVEL);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(WORD_MASK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(WORD_RAW);
    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(WORD_MSTAT);
    localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(WORD_ICLR);
    localparam logic [ADDR_W-1:0] A_DMA   = ADDR_W'(WORD_DMA);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'((1 << ADDR_W) - 8);

    regs_t r_d, r_q;

    logic              wr_acc, rd_acc, pop_req, push;
    logic [BYTE_W-1:0] head_data;
    logic [CNT_W-1:0]  q_count, cnt_after_pop, cnt_next;
    int_bits_t         raw, mask_bits, clr_bits;
    logic [7:0]        ident_val;

    assign wr_acc    = bus_sel && bus_wr;
    assign rd_acc    = bus_sel && !bus_wr;
    assign pop_req   = rd_acc && (bus_addr == A_DATA);
    assign push      = rx_valid && rx_ready;
    assign mask_bits = '{tx: r_q.mask[5], rx: r_q.mask[4]};
    assign clr_bits  = '{tx: bus_wdata[5], rx: bus_wdata[4]};

    uart_rx_queue #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .single_mode   (!r_q.line[LINE_QUEUE_BIT]),
        .push          (push),
        .push_data     (rx_data),
        .pop           (pop_req),
        .ready         (rx_ready),
        .head_data     (head_data),
        .count         (q_count),
        .cnt_after_pop (cnt_after_pop),
        .cnt_next      (cnt_next)
    );

    uart_int_status #(.TRIGGER(RX_TRIGGER), .CNT_W(CNT_W)) u_int (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_en        (wr_acc && (bus_addr == A_ICLR)),
        .clr_bits      (clr_bits),
        .pop           (pop_req),
        .push          (push),
        .cnt_after_pop (cnt_after_pop),
        .cnt_next      (cnt_next),
        .tx_set        (wr_acc && (bus_addr == A_DATA)),
        .mask          (mask_bits),
        .raw           (raw),
        .irq           (irq)
    );

    uart_ident_rom u_ident (
        .sel   (bus_addr[2:0]),
        .value (ident_val)
    );

    always_comb begin
        r_d = r_q;
        r_d.tx_stb = 1'b0;
        if (wr_acc) begin
            case (bus_addr)
                A_DATA: begin
                    r_d.tx_stb  = 1'b1;
                    r_d.tx_byte = bus_wdata[BYTE_W-1:0];
                end
                A_IDIV:  r_d.idiv  = bus_wdata[CFG_W-1:0];
                A_FDIV:  r_d.fdiv  = bus_wdata[CFG_W-1:0];
                A_LINE:  r_d.line  = bus_wdata[CFG_W-1:0];
                A_CTRL:  r_d.ctrl  = bus_wdata[CFG_W-1:0];
                A_LEVEL: r_d.level = bus_wdata[CFG_W-1:0];
                A_MASK:  r_d.mask  = bus_wdata[CFG_W-1:0];
                A_DMA:   r_d.dma   = bus_wdata[CFG_W-1:0];
                default: ;
            endcase
        end
        if (pop_req) begin
            r_d.rx_full = 1'b0;
            if (cnt_after_pop == '0) r_d.rx_empty = 1'b1;
        end
        if (push) begin
            r_d.rx_empty = 1'b0;
            if (cnt_next == CNT_W'(DEPTH) || r_q.ctrl[CTRL_FULL_BIT]) r_d.rx_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.ctrl     <= CFG_W'(16'h0300);
            r_q.level    <= CFG_W'(16'h0012);
            r_q.rx_empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr >= A_IDENT) begin
                bus_rdata = {24'b0, ident_val};
            end else begin
                case (bus_addr)
                    A_DATA:  bus_rdata = {{(32-BYTE_W){1'b0}}, head_data};
                    A_FLAGS: bus_rdata = {24'b0, 1'b1, r_q.rx_full, 1'b0, r_q.rx_empty, 4'b0};
                    A_IDIV:  bus_rdata = 32'(r_q.idiv);
                    A_FDIV:  bus_rdata = 32'(r_q.fdiv);
                    A_LINE:  bus_rdata = 32'(r_q.line);
                    A_CTRL:  bus_rdata = 32'(r_q.ctrl);
                    A_LEVEL: bus_rdata = 32'(r_q.level);
                    A_MASK:  bus_rdata = 32'(r_q.mask);
                    A_RAW:   bus_rdata = {26'b0, raw.tx, raw.rx, 4'b0};
                    A_MSTAT: bus_rdata = {26'b0, raw.tx & mask_bits.tx, raw.rx & mask_bits.rx, 4'b0};
                    A_DMA:   bus_rdata = 32'(r_q.dma);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign tx_strobe = r_q.tx_stb;
    assign tx_data   = r_q.tx_byte;

    assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr_acc && (bus_addr == A_DATA)));

    assert_empty_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rx_empty |-> (q_count == '0));

    assert_refuse_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/tb_uart_regs_top.sv
`timescale 1ns/1ps
module tb_uart_regs_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel, wr;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  rxd;
    logic        rxv;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_strobe;
    logic        irq;

    always #10 clk = ~clk;

    uart_regs_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .rx_data(rxd), .rx_valid(rxv),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_strobe(tx_strobe), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    byte unsigned q[$];
    int m_idiv, m_fdiv, m_line, m_ctrl, m_level, m_dma, m_mask;
    bit m_full, m_empty, m_rawrx, m_rawtx, m_stb;
    byte unsigned m_tx;
    byte unsigned ident[8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(int a);
        logic [31:0] v;
        v = 0;
        if (a >= 1016) v = 32'(ident[a-1016]);
        else case (a)
            0:  v = (q.size() > 0) ? 32'(q[0]) : 0;
            6:  v = {24'b0, 1'b1, m_full, 1'b0, m_empty, 4'b0};
            9:  v = 32'(m_idiv);
            10: v = 32'(m_fdiv);
            11: v = 32'(m_line);
            12: v = 32'(m_ctrl);
            13: v = 32'(m_level);
            14: v = 32'(m_mask);
            15: v = {26'b0, m_rawtx, m_rawrx, 4'b0};
            16: v = {26'b0, m_rawtx & m_mask[5], m_rawrx & m_mask[4], 4'b0};
            18: v = 32'(m_dma);
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic idle();
        sel = 0; wr = 0; addr = 0; wdata = 0; rxv = 0; rxd = 0;
    endtask

    task automatic step(string tag);
        int cap, sz, a;
        bit exp_ready, pop, push, old_ctrl4;
        #2;
        cap = m_line[4] ? 16 : 1;
        exp_ready = q.size() < cap;
        chk({tag, " ready"}, 32'(rx_ready), 32'(exp_ready));
        a = int'(addr);
        if (sel && !wr && !(a == 0 && q.size() == 0))
            chk({tag, " rdata"}, rdata, exp_read(a));
        @(posedge clk);
        pop  = sel && !wr && a == 0;
        push = rxv && exp_ready;
        old_ctrl4 = m_ctrl[4];
        m_stb = 0;
        if (sel && wr) begin
            case (a)
                0:  begin m_stb = 1; m_tx = wdata[7:0]; m_rawtx = 1; end
                9:  m_idiv = int'(wdata[15:0]);
                10: m_fdiv = int'(wdata[15:0]);
                11: m_line = int'(wdata[15:0]);
                12: m_ctrl = int'(wdata[15:0]);
                13: m_level = int'(wdata[15:0]);
                14: m_mask = int'(wdata[15:0]);
                17: begin if (wdata[4]) m_rawrx = 0; if (wdata[5]) m_rawtx = 0; end
                18: m_dma = int'(wdata[15:0]);
                default: ;
            endcase
        end
        if (pop) begin
            if (q.size() > 0) void'(q.pop_front());
            m_full = 0;
            if (q.size() == 0) begin m_empty = 1; m_rawrx = 0; end
        end
        if (push) begin
            q.push_back(rxd);
            m_empty = 0;
            sz = q.size();
            if (sz == 16 || old_ctrl4) m_full = 1;
            if (sz == 1) m_rawrx = 1;
        end
        @(negedge clk);
        chk({tag, " irq"}, 32'(irq), 32'((m_rawrx & m_mask[4]) | (m_rawtx & m_mask[5])));
        chk({tag, " tx_strobe"}, 32'(tx_strobe), 32'(m_stb));
        if (m_stb) chk({tag, " tx_data"}, 32'(tx_data), 32'(m_tx));
        idle();
    endtask

    task automatic wr_word(string tag, int a, logic [31:0] d);
        sel = 1; wr = 1; addr = 10'(a); wdata = d; step(tag);
    endtask
    task automatic rd_word(string tag, int a);
        sel = 1; wr = 0; addr = 10'(a); step(tag);
    endtask
    task automatic give(string tag, byte unsigned b);
        rxv = 1; rxd = b; step(tag);
    endtask

    initial begin
        idle();
        rst_n = 0;
        m_idiv = 0; m_fdiv = 0; m_line = 0; m_ctrl = 'h300; m_level = 'h12;
        m_dma = 0; m_mask = 0; m_full = 0; m_empty = 1; m_rawrx = 0; m_rawtx = 0; m_stb = 0; m_tx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_word("R1 flags", 6);
        rd_word("R1 level", 13);
        rd_word("R1 ctrl", 12);
        rd_word("R1 raw", 15);
        // R2 single holding slot
        give("R2 first byte", 8'hA5);
        give("R2 refused byte", 8'h3C);
        rd_word("R4 flags after accept", 6);
        // R7/R5 mask and receive interrupt
        wr_word("R7 mask", 14, 32'h30);
        rd_word("R7 raw", 15);
        rd_word("R7 masked", 16);
        rd_word("R2 held byte kept", 0);
        rd_word("R5 flags after drain", 6);
        rd_word("R5 raw after drain", 15);
        // R6 transmit
        wr_word("R6 send", 0, 32'hFFFF_FF5A);
        rd_word("R6 raw tx", 15);
        wr_word("R7 clear tx", 17, 32'h20);
        rd_word("R7 masked after clear", 16);
        // R3 sixteen-entry queue
        wr_word("R3 queue mode", 11, 32'h10);
        for (int i = 0; i < 16; i++) give("R3 fill", 8'(i * 7 + 1));
        give("R3 refused when full", 8'hEE);
        rd_word("R4 flags full", 6);
        for (int i = 0; i < 16; i++) rd_word("R3 order", 0);
        rd_word("R4 flags empty", 6);
        // R4 control bit forces full flag
        wr_word("R4 ctrl", 12, 32'h310);
        give("R4 one byte", 8'h42);
        rd_word("R4 full by ctrl", 6);
        rd_word("R4 pop", 0);
        rd_word("R4 flags cleared", 6);
        wr_word("R4 ctrl back", 12, 32'h300);
        // R11 read and accept in one cycle
        give("R11 pre a", 8'h61);
        give("R11 pre b", 8'h62);
        sel = 1; wr = 0; addr = 0; rxv = 1; rxd = 8'h63; step("R11 both");
        rd_word("R11 drain", 0);
        rd_word("R11 drain", 0);
        rd_word("R11 flags", 6);
        // R5 push while pop of last: clear then set
        give("R11 single", 8'h70);
        sel = 1; wr = 0; addr = 0; rxv = 1; rxd = 8'h71; step("R11 pop last and push");
        rd_word("R11 raw kept", 15);
        rd_word("R11 data", 0);
        // R7 clear and set same cycle
        rxv = 1; rxd = 8'h80; sel = 1; wr = 1; addr = 17; wdata = 32'h10; step("R7 set wins");
        rd_word("R7 raw after race", 15);
        rd_word("R7 drain", 0);
        // R8 config words
        wr_word("R8 idiv", 9, 32'h1234_ABCD);
        wr_word("R8 fdiv", 10, 32'h0000_0017);
        wr_word("R8 level", 13, 32'hFFFF_0024);
        wr_word("R8 dma", 18, 32'h0000_0005);
        wr_word("R8 line", 11, 32'h0000_0070);
        rd_word("R8 idiv", 9);
        rd_word("R8 fdiv", 10);
        rd_word("R8 level", 13);
        rd_word("R8 dma", 18);
        rd_word("R8 line", 11);
        // R9 identification
        for (int i = 1016; i < 1024; i++) rd_word("R9 ident", i);
        // R10 unassigned words
        wr_word("R10 write word1", 1, 32'hFFFF_FFFF);
        wr_word("R10 write word6", 6, 32'hFFFF_FFFF);
        wr_word("R10 write word40", 40, 32'hFFFF_FFFF);
        rd_word("R10 ctrl untouched", 12);
        rd_word("R10 flags untouched", 6);
        rd_word("R10 word2 zero", 2);
        rd_word("R10 word40 zero", 40);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule